// File: doc/BRIEF.md
# Port Width and Byte-Order Adapter

This block joins a 36-bit internal FIFO word path to an external port that can run 36, 18 or 9 bits wide. On the write side it collects narrow transfers from the port into whole 36-bit words and hands each finished word to the FIFO core with one write pulse. On the read side it takes a word from the FIFO core and returns it to the port as a series of narrow transfers. An optional byte-order reversal, which converts between big-endian and little-endian, is applied to the whole word. On the write side this happens after packing. On the read side it happens before splitting.

The internal word is four 9-bit bytes. Width and reversal settings come from a control register outside the block and may change while traffic flows. A width change restarts packing and unpacking at a word boundary, and any partly assembled or partly delivered word is dropped. All port and FIFO controls are sampled on the rising edge of the single port clock. The FIFO core presents its head word in show-ahead form, and the adapter pops it with a single-cycle enable.

Top module: `port_width_adapter`

## Requirements
- R1: While reset is low, and on the first cycle after it, fifo_wr_en and port_rd_valid are 0. Reset discards any partly packed or partly unpacked word.
- R2: With cfg_width code 0 (36-bit), every port write causes fifo_wr_en to be 1 on the following cycle. fifo_wr_data then equals the written word, or its byte reversal when cfg_swap is 1.
- R3: With cfg_width code 1 (18-bit), a word takes two writes. The first carries word bits 35:18 and the second carries bits 17:0, each in port_wr_data[17:0]. The upper port bits are ignored.
- R4: With cfg_width code 2 (9-bit), a word takes four writes, most significant byte (bits 35:27) first, each in port_wr_data[8:0].
- R5: fifo_wr_en pulses for one cycle, only in the cycle after the write that carries the final piece of a word. Earlier pieces cause no FIFO write.
- R6: With 36-bit width, port_rd_en raises fifo_rd_en in the same cycle. The head word appears on port_rd_data in the next cycle.
- R7: With 18-bit or 9-bit width, fifo_rd_en is raised only for the first piece of a word. Pieces come out most significant first, right-aligned in port_rd_data with the upper bits zero.
- R8: When cfg_swap is 1, byte k (bits 9k+8:9k) of the word trades places with byte 3-k. This is applied to the full word after write packing and before read splitting.
- R9: When cfg_width changes, any partial word is dropped on both sides. A transfer in the cycle of the change is the first piece of a new word under the new width.
- R10: cfg_width code 3 behaves as code 0 (36-bit).
- R11: port_rd_valid is 1 exactly in the cycle after a cycle with port_rd_en high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_width | input | 2 | Port width code: 0=36, 1=18, 2=9, 3=36 |
| cfg_swap | input | 1 | Byte-order reversal enable |
| port_wr_en | input | 1 | Port write strobe |
| port_wr_data | input | 36 | Port write data, narrow pieces right-aligned |
| fifo_wr_en | output | 1 | Write pulse to the FIFO core |
| fifo_wr_data | output | 36 | Packed word to the FIFO core |
| port_rd_en | input | 1 | Port read request |
| port_rd_data | output | 36 | Port read data, narrow pieces right-aligned |
| port_rd_valid | output | 1 | port_rd_data carries a piece this cycle |
| fifo_rd_en | output | 1 | Pop strobe to the FIFO core |
| fifo_rd_data | input | 36 | Head word of the FIFO core (show-ahead) |

## Verification
The assertions check the per-cycle handshake rules on every cycle:
- a FIFO write only ever follows a port write;
- in full-width mode every write and every read maps one-to-one onto the FIFO;
- a pop never happens without a port request;
- read-valid tracks the request one cycle later.

Only the bench scenarios can show the following:
- the piece order and data content of narrow packing and splitting;
- the byte-reversal mapping;
- that a partial word is dropped on a width change or a reset;
- that the held word, and not the live FIFO head, feeds later read pieces.

// File: rtl/pwa_pkg.sv
// Shared types for the port width adapter.
// Assumes: internal word is a whole number of bytes, byte count even.
package pwa_pkg;

    // Normalised port width selection
    typedef enum logic [1:0] {
        PW_FULL = 2'd0,
        PW_HALF = 2'd1,
        PW_BYTE = 2'd2
    } pw_mode_e;

endpackage

// File: rtl/pwa_byte_rev.sv
// Byte-order reversal: when en is high, byte k of the word moves to byte
// BYTES-1-k; otherwise the word passes unchanged. Purely combinational.
// Assumes: word width is BYTE_W*BYTES.
module pwa_byte_rev #(
    parameter int BYTE_W = 9,
    parameter int BYTES  = 4
) (
    input  logic                      en,
    input  logic [BYTE_W*BYTES-1:0]   din,
    output logic [BYTE_W*BYTES-1:0]   dout
);
    localparam int WORD_W = BYTE_W * BYTES;

    logic [WORD_W-1:0] mirrored;

    // Mirror byte lanes
    for (genvar k = 0; k < BYTES; k++) begin : g_lane
        assign mirrored[k*BYTE_W +: BYTE_W] = din[(BYTES-1-k)*BYTE_W +: BYTE_W];
    end

    // Select reversed or straight word
    assign dout = en ? mirrored : din;
endmodule

// File: rtl/pwa_pack.sv
// Write-side packer: gathers 1, 2 or BYTES narrow pieces (most significant
// first) into one word, optionally reverses byte order, and issues a
// registered one-cycle FIFO write when the final piece arrives.
// Assumes: mode is already normalised; a mode change restarts the word.
module pwa_pack
    import pwa_pkg::*;
#(
    parameter int BYTE_W = 9,
    parameter int BYTES  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  pw_mode_e                  mode,
    input  logic                      swap,
    input  logic                      wr_en,
    input  logic [BYTE_W*BYTES-1:0]   din,
    output logic                      fifo_wr_en,
    output logic [BYTE_W*BYTES-1:0]   fifo_wr_data
);
    localparam int WORD_W = BYTE_W * BYTES;
    localparam int HALF_W = WORD_W / 2;
    localparam int CNT_W  = (BYTES > 1) ? $clog2(BYTES) : 1;
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(BYTES/2 - 1);
    localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(BYTES - 1);

    pw_mode_e          mode_q;
    logic [CNT_W-1:0]  cnt_q, base_cnt;
    logic [WORD_W-1:0] acc_q, merged, packed_word;
    logic              mode_changed, last_piece;

    // Restart on width change and merge the incoming piece
    always_comb begin
        mode_changed = (mode != mode_q);
        base_cnt     = mode_changed ? '0 : cnt_q;
        case (mode)
            PW_HALF: begin
                merged     = {acc_q[HALF_W-1:0], din[HALF_W-1:0]};
                last_piece = (base_cnt == HALF_LAST);
            end
            PW_BYTE: begin
                merged     = {acc_q[WORD_W-BYTE_W-1:0], din[BYTE_W-1:0]};
                last_piece = (base_cnt == BYTE_LAST);
            end
            default: begin
                merged     = din;
                last_piece = 1'b1;
            end
        endcase
    end

    pwa_byte_rev #(.BYTE_W(BYTE_W), .BYTES(BYTES)) rev_i (
        .en   (swap),
        .din  (merged),
        .dout (packed_word)
    );

    // Track piece position and emit finished words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q       <= PW_FULL;
            cnt_q        <= '0;
            acc_q        <= '0;
            fifo_wr_en   <= 1'b0;
            fifo_wr_data <= '0;
        end else begin
            mode_q     <= mode;
            fifo_wr_en <= 1'b0;
            if (wr_en) begin
                if (last_piece) begin
                    fifo_wr_en   <= 1'b1;
                    fifo_wr_data <= packed_word;
                    cnt_q        <= '0;
                end else begin
                    acc_q <= merged;
                    cnt_q <= base_cnt + 1'b1;
                end
            end else if (mode_changed) begin
                cnt_q <= '0;
            end
        end
    end
endmodule

// File: rtl/pwa_unpack.sv
// Read-side splitter: on the first piece of a word it pops the FIFO
// (combinational strobe, show-ahead data), optionally reverses byte order,
// holds the word, and returns pieces most significant first, right-aligned.
// Assumes: mode is normalised; the caller only requests when data exists.
module pwa_unpack
    import pwa_pkg::*;
#(
    parameter int BYTE_W = 9,
    parameter int BYTES  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  pw_mode_e                  mode,
    input  logic                      swap,
    input  logic                      rd_en,
    input  logic [BYTE_W*BYTES-1:0]   fifo_rd_data,
    output logic                      fifo_rd_en,
    output logic [BYTE_W*BYTES-1:0]   dout,
    output logic                      dout_valid
);
    localparam int WORD_W = BYTE_W * BYTES;
    localparam int HALF_W = WORD_W / 2;
    localparam int CNT_W  = (BYTES > 1) ? $clog2(BYTES) : 1;
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(BYTES/2 - 1);
    localparam logic [CNT_W-1:0] BYTE_LAST = CNT_W'(BYTES - 1);

    pw_mode_e          mode_q;
    logic [CNT_W-1:0]  cnt_q, base_cnt;
    logic [WORD_W-1:0] hold_q, fresh_word, word_now, shifted, piece;
    logic              mode_changed, last_piece;

    pwa_byte_rev #(.BYTE_W(BYTE_W), .BYTES(BYTES)) rev_i (
        .en   (swap),
        .din  (fifo_rd_data),
        .dout (fresh_word)
    );

    // Choose the word source and slice out the current piece
    always_comb begin
        mode_changed = (mode != mode_q);
        base_cnt     = mode_changed ? '0 : cnt_q;
        fifo_rd_en   = rd_en && (base_cnt == '0);
        word_now     = (base_cnt == '0) ? fresh_word : hold_q;
        case (mode)
            PW_HALF: begin
                shifted    = word_now << (int'(base_cnt) * HALF_W);
                piece      = {{(WORD_W-HALF_W){1'b0}}, shifted[WORD_W-1 -: HALF_W]};
                last_piece = (base_cnt == HALF_LAST);
            end
            PW_BYTE: begin
                shifted    = word_now << (int'(base_cnt) * BYTE_W);
                piece      = {{(WORD_W-BYTE_W){1'b0}}, shifted[WORD_W-1 -: BYTE_W]};
                last_piece = (base_cnt == BYTE_LAST);
            end
            default: begin
                shifted    = word_now;
                piece      = word_now;
                last_piece = 1'b1;
            end
        endcase
    end

    // Register the piece and advance the position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= PW_FULL;
            cnt_q      <= '0;
            hold_q     <= '0;
            dout       <= '0;
            dout_valid <= 1'b0;
        end else begin
            mode_q     <= mode;
            dout_valid <= rd_en;
            if (rd_en) begin
                dout <= piece;
                if (base_cnt == '0) hold_q <= fresh_word;
                cnt_q <= last_piece ? '0 : base_cnt + 1'b1;
            end else if (mode_changed) begin
                cnt_q <= '0;
            end
        end
    end
endmodule

// File: rtl/port_width_adapter.sv
// Top of the port width adapter: decodes the width code, then drives the
// write packer and read splitter that share width and reversal settings.
// Assumes: single port clock, FIFO core supplies show-ahead read data.
module port_width_adapter
    import pwa_pkg::*;
#(
    parameter int BYTE_W = 9,
    parameter int BYTES  = 4,
    localparam int WORD_W = BYTE_W * BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_width,
    input  logic              cfg_swap,
    input  logic              port_wr_en,
    input  logic [WORD_W-1:0] port_wr_data,
    output logic              fifo_wr_en,
    output logic [WORD_W-1:0] fifo_wr_data,
    input  logic              port_rd_en,
    output logic [WORD_W-1:0] port_rd_data,
    output logic              port_rd_valid,
    output logic              fifo_rd_en,
    input  logic [WORD_W-1:0] fifo_rd_data
);
    pw_mode_e mode;

    // Decode width code, unused code falls back to full width
    always_comb begin
        case (cfg_width)
            2'd1:    mode = PW_HALF;
            2'd2:    mode = PW_BYTE;
            default: mode = PW_FULL;
        endcase
    end

    pwa_pack #(.BYTE_W(BYTE_W), .BYTES(BYTES)) pack_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode         (mode),
        .swap         (cfg_swap),
        .wr_en        (port_wr_en),
        .din          (port_wr_data),
        .fifo_wr_en   (fifo_wr_en),
        .fifo_wr_data (fifo_wr_data)
    );

    pwa_unpack #(.BYTE_W(BYTE_W), .BYTES(BYTES)) unpack_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode         (mode),
        .swap         (cfg_swap),
        .rd_en        (port_rd_en),
        .fifo_rd_data (fifo_rd_data),
        .fifo_rd_en   (fifo_rd_en),
        .dout         (port_rd_data),
        .dout_valid   (port_rd_valid)
    );
endmodule

// File: rtl/pwa_chk.sv
// Protocol checker for the port width adapter, bound to the top module.
module pwa_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] cfg_width,
    input logic       port_wr_en,
    input logic       fifo_wr_en,
    input logic       port_rd_en,
    input logic       port_rd_valid,
    input logic       fifo_rd_en
);
    logic full_mode;
    assign full_mode = (cfg_width != 2'd1) && (cfg_width != 2'd2);

    // R5
    wr_follows_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr_en |-> $past(port_wr_en));

    // R2
    full_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr_en && full_mode) |=> fifo_wr_en);

    // R6
    full_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_rd_en && full_mode) |-> fifo_rd_en);

    // R7
    pop_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd_en |-> port_rd_en);

    // R11
    rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_rd_en |=> port_rd_valid);

    // R11
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !port_rd_en |=> !port_rd_valid);
endmodule

bind port_width_adapter pwa_chk chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_width     (cfg_width),
    .port_wr_en    (port_wr_en),
    .fifo_wr_en    (fifo_wr_en),
    .port_rd_en    (port_rd_en),
    .port_rd_valid (port_rd_valid),
    .fifo_rd_en    (fifo_rd_en)
);

// File: tb/port_width_adapter_tb_top.sv
module port_width_adapter_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_width = 2'd0;
    logic        cfg_swap = 1'b0;
    logic        port_wr_en = 1'b0;
    logic [35:0] port_wr_data = '0;
    logic        fifo_wr_en;
    logic [35:0] fifo_wr_data;
    logic        port_rd_en = 1'b0;
    logic [35:0] port_rd_data;
    logic        port_rd_valid;
    logic        fifo_rd_en;
    logic [35:0] fifo_rd_data = '0;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    port_width_adapter dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_swap(cfg_swap),
        .port_wr_en(port_wr_en), .port_wr_data(port_wr_data),
        .fifo_wr_en(fifo_wr_en), .fifo_wr_data(fifo_wr_data),
        .port_rd_en(port_rd_en), .port_rd_data(port_rd_data),
        .port_rd_valid(port_rd_valid), .fifo_rd_en(fifo_rd_en),
        .fifo_rd_data(fifo_rd_data)
    );

    localparam logic [8:0] B3 = 9'h1A1, B2 = 9'h0B2, B1 = 9'h1C3, B0 = 9'h0D4;
    localparam logic [35:0] W1  = {B3, B2, B1, B0};
    localparam logic [35:0] RW1 = {B0, B1, B2, B3};
    localparam logic [35:0] W2  = {9'h111, 9'h022, 9'h133, 9'h044};
    localparam logic [35:0] W3  = {9'h055, 9'h066, 9'h077, 9'h088};
    localparam logic [26:0] JB  = 27'h5A5A5A5;
    localparam logic [17:0] JH  = 18'h2AAAA;

    typedef struct packed {
        logic [1:0]  mode;
        logic        swap;
        logic [35:0] din;
        logic        exp_wr;
        logic [35:0] exp_word;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, W1,                   1'b1, W1},   // R2
        '{2'd0, 1'b1, W1,                   1'b1, RW1},  // R2 R8
        '{2'd1, 1'b0, {JH, B3, B2},         1'b0, '0},   // R3 R5
        '{2'd1, 1'b0, {JH, B1, B0},         1'b1, W1},   // R3
        '{2'd2, 1'b0, {JB, B3},             1'b0, '0},   // R4 R5
        '{2'd2, 1'b0, {JB, B2},             1'b0, '0},
        '{2'd2, 1'b0, {JB, B1},             1'b0, '0},
        '{2'd2, 1'b0, {JB, B0},             1'b1, W1},   // R4
        '{2'd2, 1'b1, {JB, B3},             1'b0, '0},   // R8
        '{2'd2, 1'b1, {JB, B2},             1'b0, '0},
        '{2'd2, 1'b1, {JB, B1},             1'b0, '0},
        '{2'd2, 1'b1, {JB, B0},             1'b1, RW1},  // R8
        '{2'd1, 1'b0, {JH, B3, B2},         1'b0, '0},   // R9 partial
        '{2'd2, 1'b0, {JB, 9'h055},         1'b0, '0},   // R9 change
        '{2'd2, 1'b0, {JB, 9'h066},         1'b0, '0},
        '{2'd2, 1'b0, {JB, 9'h077},         1'b0, '0},
        '{2'd2, 1'b0, {JB, 9'h088},         1'b1, W3},   // R9
        '{2'd3, 1'b0, W2,                   1'b1, W2}    // R10
    };

    task automatic chk(input logic [35:0] act, input logic [35:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd_step(input logic [1:0] w, input logic sw, input logic [35:0] head,
                           input logic exp_pop, input logic [35:0] exp_data, input string tag);
        @(negedge clk);
        cfg_width = w; cfg_swap = sw; fifo_rd_data = head; port_rd_en = 1'b1;
        #1 chk({35'd0, fifo_rd_en}, {35'd0, exp_pop}, {tag, " pop"});
        @(posedge clk);
        #1;
        chk({35'd0, port_rd_valid}, 36'd1, {tag, " valid"});
        chk(port_rd_data, exp_data, {tag, " data"});
    endtask

    task automatic wr_piece(input logic [1:0] w, input logic [35:0] d);
        @(negedge clk);
        cfg_width = w; port_wr_en = 1'b1; port_wr_data = d;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk({35'd0, fifo_wr_en}, 36'd0, "R1 wr_en in reset");
        chk({35'd0, port_rd_valid}, 36'd0, "R1 rd_valid in reset");
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        chk({35'd0, fifo_wr_en}, 36'd0, "R1 wr_en after reset");
        chk({35'd0, port_rd_valid}, 36'd0, "R1 rd_valid after reset");

        // Write-side vector table
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            cfg_width = VECS[i].mode; cfg_swap = VECS[i].swap;
            port_wr_en = 1'b1; port_wr_data = VECS[i].din;
            @(posedge clk);
            #1;
            chk({35'd0, fifo_wr_en}, {35'd0, VECS[i].exp_wr}, $sformatf("R5 vec%0d wr_en", i));
            if (VECS[i].exp_wr)
                chk(fifo_wr_data, VECS[i].exp_word, $sformatf("R2/R3/R4 vec%0d word", i));
        end
        @(negedge clk) port_wr_en = 1'b0; cfg_swap = 1'b0;
        @(posedge clk); #1;
        chk({35'd0, fifo_wr_en}, 36'd0, "R5 idle no write");

        // R1: reset drops a partial packed word
        wr_piece(2'd2, {JB, 9'h1FF});
        @(negedge clk) port_wr_en = 1'b0; rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        wr_piece(2'd2, {JB, B3});
        wr_piece(2'd2, {JB, B2});
        wr_piece(2'd2, {JB, B1});
        chk({35'd0, fifo_wr_en}, 36'd0, "R1 no early write after reset");
        wr_piece(2'd2, {JB, B0});
        chk({35'd0, fifo_wr_en}, 36'd1, "R1 word after reset");
        chk(fifo_wr_data, W1, "R1 word after reset data");
        @(negedge clk) port_wr_en = 1'b0;

        // Read side
        rd_step(2'd0, 1'b0, W1, 1'b1, W1, "R6 full read");
        rd_step(2'd2, 1'b0, W1, 1'b1, {27'd0, B3}, "R7 byte p0");
        rd_step(2'd2, 1'b0, W2, 1'b0, {27'd0, B2}, "R7 byte p1 held");
        rd_step(2'd2, 1'b0, W2, 1'b0, {27'd0, B1}, "R7 byte p2 held");
        rd_step(2'd2, 1'b0, W2, 1'b0, {27'd0, B0}, "R7 byte p3 held");
        rd_step(2'd1, 1'b1, W1, 1'b1, {18'd0, B0, B1}, "R8 half swap p0");
        rd_step(2'd1, 1'b1, W2, 1'b0, {18'd0, B2, B3}, "R8 half swap p1");
        rd_step(2'd2, 1'b0, W1, 1'b1, {27'd0, B3}, "R9 byte p0");
        rd_step(2'd1, 1'b0, W2, 1'b1, {18'd0, W2[35:18]}, "R9 change restarts");
        rd_step(2'd3, 1'b0, W3, 1'b1, W3, "R10 code3 read");
        @(negedge clk) port_rd_en = 1'b0;
        #1 chk({35'd0, fifo_rd_en}, 36'd0, "R7 no pop without request");
        @(posedge clk); #1;
        chk({35'd0, port_rd_valid}, 36'd0, "R11 valid drops");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule